// File: doc/BRIEF.md
# Indirect Configuration Register Port with Unlock-Keyed Soft Reset

This block is the host-facing register front end of a serial bus controller. The host sees only a small direct address space: a pointer register and a data window. The index held in the pointer selects one entry of an indirect configuration bank, and every access to the window reads or writes that entry. The bank holds the bus mode, the clock-low count, the clock-high count, the controller's own address and a timeout value. These settings drive the bus engine through dedicated output ports.

The host can restart the controller without a reset pin. It points at the reset index and writes the two key bytes 0xA5 and 0x5A through the window, in that order. The cycle after the second byte is accepted, a one-cycle soft-reset flag goes high. On that cycle the whole bank and the pointer return to their defaults. The timing and mode settings are then lost, and the host has to program them again. The own-address entry returns whatever was last written to it, so software can probe for the indirect bank by writing a pattern and reading it back.

Top module: `cfg_window_regs`

## Requirements
- R1: Out of reset, the pointer reads 0, the outputs hold their defaults (mode 0x00, clock-low 0x9D, clock-high 0x86, own address 0xE0, timeout 0xFF) and `soft_rst_o` is low.
- R2: A write to direct address 0 loads the low IDX_W bits (3 by default) of the data into the pointer. A read of address 0 returns the pointer with its upper bits zero.
- R3: A write to direct address 1 updates the indirect entry that the pointer selects: index 0 mode, 1 clock-low, 2 clock-high, 3 own address, 4 timeout. The new value appears on that entry's output and reads back through address 1.
- R4: A value written to the own-address entry (index 3) reads back unchanged in all 8 bits.
- R5: Two window writes to the reset index (6) arm the soft reset: 0xA5 first, then 0x5A. After the clock edge that accepts 0x5A, `soft_rst_o` is high for exactly one cycle.
- R6: The clock edge that ends the `soft_rst_o` cycle returns all five entries and the pointer to their R1 values. A host write presented in that cycle is dropped.
- R7: A wrong byte at the reset index makes the key detector wait for 0xA5 again. This includes 0xA5 sent a second time. A window write to any other index has the same effect. A pointer write leaves the key progress unchanged.
- R8: The pointer never changes on its own. Repeated window accesses keep hitting the same entry.
- R9: Reads of indices 5, 6 and 7 through the window return 0x00, and window writes to indices 5 and 7 change no entry.
- R10: Reads of direct addresses 2 and 3 return 0x00, and writes to them change neither the pointer nor any entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Write strobe, one byte per cycle |
| host_addr | input | 2 | Direct address: 0 pointer, 1 window |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for the current address (combinational) |
| cfg_mode | output | 8 | Bus mode setting |
| cfg_scl_lo | output | 8 | Clock-low count |
| cfg_scl_hi | output | 8 | Clock-high count |
| cfg_own_addr | output | 8 | Own bus address |
| cfg_timeout | output | 8 | Timeout setting |
| soft_rst_o | output | 1 | One-cycle soft-reset flag |

## Verification
The assertions check four rules on every cycle:
- The soft-reset flag never lasts more than one cycle.
- The flag always follows an accepted 0x5A at the reset index.
- Every setting is back at its default the cycle after the flag.
- The settings and the pointer hold their values unless the host writes them.

Only the bench scenarios show that the key detector re-arms correctly after wrong bytes, doubled first bytes and detours to other indices. They also show that pointer writes do not break the key sequence, that the own-address entry reads back intact and that unused indices read as zero.

// File: rtl/cfg_window_regs.sv
module cfg_window_regs #(
  parameter int IDX_W = 3,
  parameter int DW = 8,
  parameter int IDX_MODE = 0,
  parameter int IDX_LO = 1,
  parameter int IDX_HI = 2,
  parameter int IDX_OWN = 3,
  parameter int IDX_TMO = 4,
  parameter int IDX_RST = 6,
  parameter logic [7:0] KEY_A = 8'hA5,
  parameter logic [7:0] KEY_B = 8'h5A,
  parameter logic [7:0] DEF_MODE = 8'h00,
  parameter logic [7:0] DEF_LO = 8'h9D,
  parameter logic [7:0] DEF_HI = 8'h86,
  parameter logic [7:0] DEF_OWN = 8'hE0,
  parameter logic [7:0] DEF_TMO = 8'hFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic [1:0]    host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic [DW-1:0] cfg_mode,
  output logic [DW-1:0] cfg_scl_lo,
  output logic [DW-1:0] cfg_scl_hi,
  output logic [DW-1:0] cfg_own_addr,
  output logic [DW-1:0] cfg_timeout,
  output logic          soft_rst_o
);
  localparam logic [1:0] A_PTR = 2'd0;
  localparam logic [1:0] A_WIN = 2'd1;

  logic [IDX_W-1:0] ptr;
  logic             key_half;
  logic [DW-1:0]    win_rd;

  wire ptr_wr  = host_wr && host_addr == A_PTR;
  wire win_wr  = host_wr && host_addr == A_WIN;
  wire at_rst  = ptr == IDX_W'(IDX_RST);
  wire key_ok  = win_wr && at_rst && key_half && host_wdata == DW'(KEY_B);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
      cfg_mode <= DEF_MODE;
      cfg_scl_lo <= DEF_LO;
      cfg_scl_hi <= DEF_HI;
      cfg_own_addr <= DEF_OWN;
      cfg_timeout <= DEF_TMO;
    end else if (soft_rst_o) begin
      ptr <= '0;
      cfg_mode <= DEF_MODE;
      cfg_scl_lo <= DEF_LO;
      cfg_scl_hi <= DEF_HI;
      cfg_own_addr <= DEF_OWN;
      cfg_timeout <= DEF_TMO;
    end else if (ptr_wr) begin
      ptr <= host_wdata[IDX_W-1:0];
    end else if (win_wr) begin
      if (ptr == IDX_W'(IDX_MODE)) cfg_mode <= host_wdata;
      if (ptr == IDX_W'(IDX_LO))   cfg_scl_lo <= host_wdata;
      if (ptr == IDX_W'(IDX_HI))   cfg_scl_hi <= host_wdata;
      if (ptr == IDX_W'(IDX_OWN))  cfg_own_addr <= host_wdata;
      if (ptr == IDX_W'(IDX_TMO))  cfg_timeout <= host_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_half <= 1'b0;
      soft_rst_o <= 1'b0;
    end else if (soft_rst_o) begin
      key_half <= 1'b0;
      soft_rst_o <= 1'b0;
    end else begin
      soft_rst_o <= key_ok;
      if (win_wr)
        key_half <= at_rst && !key_half && host_wdata == DW'(KEY_A);
    end
  end

  always_comb begin
    win_rd = '0;
    if (ptr == IDX_W'(IDX_MODE)) win_rd = cfg_mode;
    if (ptr == IDX_W'(IDX_LO))   win_rd = cfg_scl_lo;
    if (ptr == IDX_W'(IDX_HI))   win_rd = cfg_scl_hi;
    if (ptr == IDX_W'(IDX_OWN))  win_rd = cfg_own_addr;
    if (ptr == IDX_W'(IDX_TMO))  win_rd = cfg_timeout;
  end

  assign host_rdata = host_addr == A_PTR ? DW'(ptr) :
                      host_addr == A_WIN ? win_rd : '0;

  p_pulse_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_o |=> !soft_rst_o);

  p_pulse_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(soft_rst_o) |-> $past(win_wr && at_rst && host_wdata == DW'(KEY_B)));

  p_defaults_r6: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_o |=> (cfg_mode == DEF_MODE && cfg_scl_lo == DEF_LO &&
                    cfg_scl_hi == DEF_HI && cfg_own_addr == DEF_OWN &&
                    cfg_timeout == DEF_TMO && ptr == '0));

  p_ptr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptr_wr && !soft_rst_o) |=> $stable(ptr));

  p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_wr && !soft_rst_o) |=> ($stable(cfg_mode) && $stable(cfg_scl_lo) &&
      $stable(cfg_scl_hi) && $stable(cfg_own_addr) && $stable(cfg_timeout)));
endmodule

// File: tb/cfg_window_regs_bench.sv
module cfg_window_regs_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_wr = 1'b0;
  logic [1:0] host_addr = 2'd0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata, cfg_mode, cfg_scl_lo, cfg_scl_hi, cfg_own_addr, cfg_timeout;
  logic soft_rst_o;
  int errors = 0;
  int checks = 0;
  int pulses = 0;

  always #2 clk = ~clk;

  cfg_window_regs u_cfg_window_regs (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .cfg_mode(cfg_mode),
    .cfg_scl_lo(cfg_scl_lo), .cfg_scl_hi(cfg_scl_hi), .cfg_own_addr(cfg_own_addr),
    .cfg_timeout(cfg_timeout), .soft_rst_o(soft_rst_o));

  always @(posedge clk) if (soft_rst_o) pulses++;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic rd_idx(input int idx, output logic [7:0] d);
    wr(2'd0, 8'(idx));
    rd(2'd1, d);
  endtask

  task automatic check_defaults(input string req);
    logic [7:0] v;
    check(req, cfg_mode, 8'h00);
    check(req, cfg_scl_lo, 8'h9D);
    check(req, cfg_scl_hi, 8'h86);
    check(req, cfg_own_addr, 8'hE0);
    check(req, cfg_timeout, 8'hFF);
    rd(2'd0, v); check(req, v, 0);
  endtask

  task automatic program_all;
    wr(0, 0); wr(1, 8'h03);
    wr(0, 1); wr(1, 8'h11);
    wr(0, 2); wr(1, 8'h22);
    wr(0, 3); wr(1, 8'h5C);
    wr(0, 4); wr(1, 8'h44);
  endtask

  task automatic t_reset_state;
    check("R1 pulse", soft_rst_o, 0);
    check_defaults("R1");
  endtask

  task automatic t_pointer;
    logic [7:0] v;
    wr(0, 8'hFB); rd(0, v); check("R2 ptr masked", v, 3);
    wr(0, 8'h04); rd(0, v); check("R2 ptr", v, 4);
  endtask

  task automatic t_window;
    logic [7:0] v;
    program_all;
    check("R3 mode", cfg_mode, 8'h03);
    check("R3 lo", cfg_scl_lo, 8'h11);
    check("R3 hi", cfg_scl_hi, 8'h22);
    check("R3 tmo", cfg_timeout, 8'h44);
    rd_idx(1, v); check("R3 lo read", v, 8'h11);
    rd_idx(4, v); check("R3 tmo read", v, 8'h44);
  endtask

  task automatic t_own_addr;
    logic [7:0] v;
    wr(0, 3); wr(1, 8'hAA); rd(1, v); check("R4 own AA", v, 8'hAA);
    wr(1, 8'h55); rd(1, v); check("R4 own 55", v, 8'h55);
  endtask

  task automatic t_no_incr;
    logic [7:0] v;
    wr(0, 2); wr(1, 8'h31); wr(1, 8'h32); rd(1, v); rd(1, v);
    check("R8 same entry", v, 8'h32);
    check("R8 neighbour", cfg_own_addr, 8'h55);
    rd(0, v); check("R8 ptr", v, 2);
  endtask

  task automatic t_unused;
    logic [7:0] v;
    wr(0, 5); wr(1, 8'h77); rd(1, v); check("R9 idx5", v, 0);
    wr(0, 7); wr(1, 8'h77); rd(1, v); check("R9 idx7", v, 0);
    wr(0, 6); rd(1, v); check("R9 idx6", v, 0);
    check("R9 mode kept", cfg_mode, 8'h03);
    check("R9 hi kept", cfg_scl_hi, 8'h32);
    wr(2, 8'h06); wr(3, 8'h99); rd(2, v); check("R10 addr2", v, 0);
    rd(3, v); check("R10 addr3", v, 0);
    rd(0, v); check("R10 ptr kept", v, 6);
    check("R10 tmo kept", cfg_timeout, 8'h44);
  endtask

  task automatic t_bad_keys;
    int p0;
    p0 = pulses;
    wr(0, 6); wr(1, 8'hA5); wr(1, 8'h00); wr(1, 8'h5A);
    wr(1, 8'hA5); wr(1, 8'hA5); wr(1, 8'h5A);
    wr(1, 8'hA5); wr(0, 0); wr(1, 8'h09); wr(0, 6); wr(1, 8'h5A);
    wr(1, 8'h5A);
    repeat (2) @(negedge clk);
    check("R7 no pulse", pulses - p0, 0);
    check("R7 mode written", cfg_mode, 8'h09);
    check("R7 lo intact", cfg_scl_lo, 8'h11);
  endtask

  task automatic t_good_key;
    int p0;
    p0 = pulses;
    wr(0, 6); wr(1, 8'hA5); wr(0, 6);
    @(negedge clk);
    host_wr = 1'b1; host_addr = 2'd1; host_wdata = 8'h5A;
    @(negedge clk);
    check("R5 pulse high", soft_rst_o, 1);
    host_addr = 2'd0; host_wdata = 8'h03;
    @(negedge clk);
    host_wr = 1'b0;
    check("R5 pulse one cycle", soft_rst_o, 0);
    check("R6 write dropped", pulses - p0, 1);
    check_defaults("R6");
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state;
    t_pointer;
    t_window;
    t_own_addr;
    t_no_incr;
    t_unused;
    t_bad_keys;
    t_good_key;
    program_all;
    t_good_key;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule